// File: doc/BRIEF.md
# Card Attribute-Space Configuration Registers

This block is the attribute-memory side of a removable I/O card. The host reaches attribute space by driving a register-select strobe and the first card enable low. It then strobes either an output enable to read or a write enable to write. A read at an even address inside the card information table returns a fixed byte. The table's contents are computed from a rule, so no list is stored. Three configuration registers sit at a parameterised base: an option register, a configuration/status register and a pin-replacement register. They can be written and read back through the same cycles.

The option register sets the I/O-function enable, interrupt routing and the interrupt-mode select. Its top bit is a soft reset. While that bit is set, the other two registers are held cleared and the function enables are forced off. The configuration/status register drives the status-change-enable output. All strobes are sampled by the block clock. Read data and the bus-drive enable are registered, so they appear one clock after the strobe is first sampled.

Top module: `cfa_attr_regs`

## Requirements
- R1: No read or write takes effect unless `reg_sel_n` and `ce1_n` are both low. In that case `rdata_oe` stays low and the register contents stay unchanged.
- R2: Table entry k (k < CIS_LEN, default 47) is at attribute address 2k. For k < CIS_LEN-1 its value is (29·k + 1) mod 256, and the last entry is 0xFF.
- R3: A read of an odd address, or of an even address that is neither a table entry nor a register, returns `rdata` = 0x00 with `rdata_oe` low.
- R4: `rdata_oe` is high only in the clock after a qualified read strobe of a mapped location was sampled. Whenever `rdata_oe` is low, `rdata` is 0x00.
- R5: After reset all three registers read 0x00, and `io_func_en`, `irq_route_en`, `irq_level_mode` and `stat_chg_en` are low.
- R6: The registers sit at CFG_BASE+0 (option), CFG_BASE+2 (configuration/status) and CFG_BASE+4 (pin replacement); the default CFG_BASE is 0x200. Read-back equals the written byte ANDed with the write mask: 0xFF, 0x7E and 0x0F respectively.
- R7: Option bit 0 enables the I/O function, bit 2 enables interrupt routing, and bit 6 selects level-mode interrupts. Writing 0x45 raises all three outputs.
- R8: Configuration/status bit 6 drives `stat_chg_en`. Writing 0x40 raises it.
- R9: While option bit 7 is set, the configuration/status and pin-replacement registers read 0x00, writes to them are dropped, and `io_func_en` and `irq_route_en` are low. Writing 0x00 to the option register ends this state.
- R10: A write strobe held low for several clocks performs one write, using the data present in its first sampled clock.
- R11: When the output enable and the write enable are low together, the cycle is a read and no write happens.
- R12: Writes to table addresses, odd addresses or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel_n | input | 1 | Attribute-space select, active low |
| ce1_n | input | 1 | Card enable for the low byte, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Attribute byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, 0x00 when not driven |
| rdata_oe | output | 1 | High while the card drives read data |
| io_func_en | output | 1 | I/O function enabled |
| irq_route_en | output | 1 | Interrupt routing enabled |
| irq_level_mode | output | 1 | Level-mode interrupt request selected |
| stat_chg_en | output | 1 | Status-change output enabled |

## Verification
A corrupted register shows at the enable outputs within one clock of the bad write. It also shows in the read-back data one clock after the next read of that address. A soft reset that fails to hold the other registers shows up as a non-zero read of the configuration/status or pin-replacement register while option bit 7 is set. A decoder fault, such as a wrong table index or a wrongly mapped odd address, shows in the clock after the read strobe of that address. So a sweep of every address finds it in a single pass. A write edge detector that fires more than once shows up as the later data overwriting the first during a held strobe.

// File: rtl/cfa_attr_pkg.sv
package cfa_attr_pkg;

   localparam int NUM_REGS = 3;

   typedef enum logic [1:0] {
      RG_OPTION = 2'd0,
      RG_CFGSTS = 2'd1,
      RG_PINREP = 2'd2
   } reg_id_e;

   // option register bit positions
   localparam int OPT_IO_EN    = 0;
   localparam int OPT_IRQ_ROUTE = 2;
   localparam int OPT_LEVEL    = 6;
   localparam int OPT_SRST     = 7;
   // configuration/status bit position
   localparam int CS_STSCHG_EN = 6;

   // card information byte k of a table of len bytes
   function automatic logic [7:0] cis_entry(input int k, input int len);
      int v;
      if (k == len - 1) return 8'hFF;
      v = (k * 29 + 1) % 256;
      return v[7:0];
   endfunction

endpackage

// File: rtl/cfa_attr_decode.sv
module cfa_attr_decode
   import cfa_attr_pkg::*;
#(
   parameter int          ADDR_W   = 11,
   parameter int          CIS_LEN  = 47,
   parameter int unsigned CFG_BASE = 'h200,
   localparam int         IDX_W    = ADDR_W - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel_n,
   input  logic                ce1_n,
   input  logic                oe_n,
   input  logic                we_n,
   input  logic [ADDR_W-1:0]   addr,
   output logic                rd_act,
   output logic                wr_stb,
   output logic                cis_hit,
   output logic [IDX_W-1:0]    cis_idx,
   output logic [NUM_REGS-1:0] reg_hit
);

   logic qual;
   logic wr_act;
   logic wr_act_q;

   assign qual    = !reg_sel_n && !ce1_n;
   assign rd_act  = qual && !oe_n;
   // read strobe wins when both are low
   assign wr_act  = qual && !we_n && oe_n;
   assign wr_stb  = wr_act && !wr_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_act_q <= 1'b0;
      else        wr_act_q <= wr_act;
   end

   assign cis_idx = addr[ADDR_W-1:1];
   assign cis_hit = !addr[0] && (cis_idx < IDX_W'(CIS_LEN));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      assign reg_hit[i] = (addr == ADDR_W'(CFG_BASE + 2 * i));
   end

endmodule

// File: rtl/cfa_cis_rom.sv
module cfa_cis_rom
   import cfa_attr_pkg::*;
#(
   parameter int CIS_LEN    = 47,
   parameter int IDX_W      = 10,
   parameter bit PRECOMPUTE = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       data
);

   if (PRECOMPUTE) begin : g_table
      logic [7:0] tbl [CIS_LEN];
      for (genvar k = 0; k < CIS_LEN; k++) begin : g_ent
         assign tbl[k] = cis_entry(k, CIS_LEN);
      end
      always_comb begin
         data = 8'h00;
         for (int k = 0; k < CIS_LEN; k++) begin
            if (idx == IDX_W'(k)) data = tbl[k];
         end
      end
   end else begin : g_arith
      always_comb begin
         if (idx < IDX_W'(CIS_LEN)) data = cis_entry(int'(idx), CIS_LEN);
         else                       data = 8'h00;
      end
   end

endmodule

// File: rtl/cfa_cfg_regs.sv
module cfa_cfg_regs
   import cfa_attr_pkg::*;
#(
   parameter logic [NUM_REGS-1:0][7:0] WMASK = {8'h0F, 8'h7E, 8'hFF}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic [NUM_REGS-1:0]      reg_hit,
   input  logic [7:0]               wdata,
   output logic [NUM_REGS-1:0][7:0] regs
);

   logic srst;
   assign srst = regs[RG_OPTION][OPT_SRST];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == int'(RG_OPTION)) begin : g_opt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     regs[i] <= 8'h00;
            else if (wr_stb && reg_hit[i])  regs[i] <= wdata & WMASK[i];
         end
      end else begin : g_held
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     regs[i] <= 8'h00;
            else if (srst)                  regs[i] <= 8'h00;
            else if (wr_stb && reg_hit[i])  regs[i] <= wdata & WMASK[i];
         end
      end
   end

endmodule

// File: rtl/cfa_attr_regs.sv
module cfa_attr_regs
   import cfa_attr_pkg::*;
#(
   parameter int          ADDR_W        = 11,
   parameter int          CIS_LEN       = 47,
   parameter int unsigned CFG_BASE      = 'h200,
   parameter logic [7:0]  OPT_WMASK     = 8'hFF,
   parameter logic [7:0]  CS_WMASK      = 8'h7E,
   parameter logic [7:0]  PR_WMASK      = 8'h0F,
   parameter bit          CIS_PRECOMPUTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel_n,
   input  logic              ce1_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              rdata_oe,
   output logic              io_func_en,
   output logic              irq_route_en,
   output logic              irq_level_mode,
   output logic              stat_chg_en
);

   localparam int IDX_W = ADDR_W - 1;

   // elaboration-time parameter checks
   if (CFG_BASE % 2 != 0) begin : g_bad_align
      $error("CFG_BASE must be even");
   end
   if (2 * CIS_LEN > CFG_BASE) begin : g_bad_overlap
      $error("table overlaps configuration registers");
   end
   if (CFG_BASE + 2 * NUM_REGS > (1 << ADDR_W)) begin : g_bad_range
      $error("configuration registers exceed address space");
   end
   if (CIS_LEN < 1) begin : g_bad_len
      $error("CIS_LEN must be positive");
   end

   logic                     rd_act;
   logic                     wr_stb;
   logic                     cis_hit;
   logic [IDX_W-1:0]         cis_idx;
   logic [NUM_REGS-1:0]      reg_hit;
   logic [7:0]               cis_data;
   logic [NUM_REGS-1:0][7:0] regs_q;
   logic                     mapped;
   logic [7:0]               rd_val;
   logic [7:0]               rdata_q;
   logic                     oe_q;

   cfa_attr_decode #(
      .ADDR_W   (ADDR_W),
      .CIS_LEN  (CIS_LEN),
      .CFG_BASE (CFG_BASE)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel_n (reg_sel_n),
      .ce1_n     (ce1_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .addr      (addr),
      .rd_act    (rd_act),
      .wr_stb    (wr_stb),
      .cis_hit   (cis_hit),
      .cis_idx   (cis_idx),
      .reg_hit   (reg_hit)
   );

   cfa_cis_rom #(
      .CIS_LEN    (CIS_LEN),
      .IDX_W      (IDX_W),
      .PRECOMPUTE (CIS_PRECOMPUTE)
   ) u_rom (
      .idx  (cis_idx),
      .data (cis_data)
   );

   cfa_cfg_regs #(
      .WMASK ({PR_WMASK, CS_WMASK, OPT_WMASK})
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .reg_hit (reg_hit),
      .wdata   (wdata),
      .regs    (regs_q)
   );

   assign mapped = cis_hit || (|reg_hit);

   always_comb begin
      rd_val = 8'h00;
      if (cis_hit) rd_val = cis_data;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (reg_hit[i]) rd_val = regs_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= 8'h00;
         oe_q    <= 1'b0;
      end else begin
         oe_q    <= rd_act && mapped;
         rdata_q <= (rd_act && mapped) ? rd_val : 8'h00;
      end
   end

   assign rdata          = rdata_q;
   assign rdata_oe       = oe_q;
   assign io_func_en     = regs_q[RG_OPTION][OPT_IO_EN] && !regs_q[RG_OPTION][OPT_SRST];
   assign irq_route_en   = regs_q[RG_OPTION][OPT_IRQ_ROUTE] && !regs_q[RG_OPTION][OPT_SRST];
   assign irq_level_mode = regs_q[RG_OPTION][OPT_LEVEL];
   assign stat_chg_en    = regs_q[RG_CFGSTS][CS_STSCHG_EN];

endmodule

// File: rtl/cfa_attr_regs_chk.sv
module cfa_attr_regs_chk
   import cfa_attr_pkg::*;
(
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_sel_n,
   input logic                     ce1_n,
   input logic                     oe_n,
   input logic [7:0]               rdata,
   input logic                     rdata_oe,
   input logic                     wr_stb,
   input logic [NUM_REGS-1:0][7:0] regs
);

   // R4: driving the bus needs a qualified read strobe one clock earlier
   a_r4_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(!reg_sel_n && !ce1_n && !oe_n));

   // R4: an undriven bus carries zero
   a_r4_quiet_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == 8'h00));

   // R1: no drive follows a cycle without register select
   a_r1_no_drive_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel_n |=> !rdata_oe);

   // R10: one write per strobe
   a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R9: soft reset clears the held registers
   a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      regs[RG_OPTION][OPT_SRST] |=> (regs[RG_CFGSTS] == 8'h00 && regs[RG_PINREP] == 8'h00));

   // R6: without a write the option register keeps its value
   a_r6_option_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(regs[RG_OPTION]));

endmodule

bind cfa_attr_regs cfa_attr_regs_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel_n (reg_sel_n),
   .ce1_n     (ce1_n),
   .oe_n      (oe_n),
   .rdata     (rdata),
   .rdata_oe  (rdata_oe),
   .wr_stb    (wr_stb),
   .regs      (regs_q)
);

// File: tb/sim_cfa_attr_regs.sv
`timescale 1ns/1ps
module sim_cfa_attr_regs;

   localparam int ADDR_W   = 11;
   localparam int CIS_LEN  = 47;
   localparam int CFG_BASE = 'h200;
   localparam int A_OPT    = CFG_BASE;
   localparam int A_CS     = CFG_BASE + 2;
   localparam int A_PR     = CFG_BASE + 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_sel_n = 1'b1;
   logic              ce1_n = 1'b1;
   logic              oe_n = 1'b1;
   logic              we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '1;
   logic [7:0]        wdata = 8'h00;
   logic [7:0]        rdata;
   logic              rdata_oe;
   logic              io_func_en;
   logic              irq_route_en;
   logic              irq_level_mode;
   logic              stat_chg_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfa_attr_regs #(.ADDR_W(ADDR_W), .CIS_LEN(CIS_LEN), .CFG_BASE(CFG_BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .ce1_n(ce1_n),
      .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .io_func_en(io_func_en),
      .irq_route_en(irq_route_en), .irq_level_mode(irq_level_mode),
      .stat_chg_en(stat_chg_en)
   );

   function automatic logic [7:0] exp_cis(input int k);
      if (k == CIS_LEN - 1) return 8'hFF;
      return 8'((k * 29 + 1) % 256);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic idle();
      reg_sel_n = 1'b1; ce1_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '1;
   endtask

   task automatic rd(input int a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = ADDR_W'(a); reg_sel_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      d = rdata; oe = rdata_oe;
      idle();
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      addr = ADDR_W'(a); wdata = d; reg_sel_n = 1'b0; ce1_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      idle();
   endtask

   task automatic rd_chk(input string tag, input int a, input int exp_d, input int exp_oe);
      logic [7:0] d;
      logic       oe;
      rd(a, d, oe);
      chk({tag, " data"}, int'(d), exp_d);
      chk({tag, " oe"}, int'(oe), exp_oe);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic       oe;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5: reset state of outputs
      chk("R5 io_func_en", int'(io_func_en), 0);
      chk("R5 irq_route_en", int'(irq_route_en), 0);
      chk("R5 irq_level_mode", int'(irq_level_mode), 0);
      chk("R5 stat_chg_en", int'(stat_chg_en), 0);
      chk("R4 idle oe", int'(rdata_oe), 0);

      // R2 R3 R5: sweep every attribute address
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         int ed, eo;
         ed = 0; eo = 0;
         if (a % 2 == 0 && a / 2 < CIS_LEN) begin ed = exp_cis(a / 2); eo = 1; end
         else if (a == A_OPT || a == A_CS || a == A_PR) begin ed = 0; eo = 1; end
         rd(a, d, oe);
         chk($sformatf("R2/R3/R5 addr 0x%0h data", a), int'(d), ed);
         chk($sformatf("R3/R4 addr 0x%0h oe", a), int'(oe), eo);
      end

      // R7 R6: option write
      wr(A_OPT, 8'h45);
      @(negedge clk);
      chk("R7 io_func_en", int'(io_func_en), 1);
      chk("R7 irq_route_en", int'(irq_route_en), 1);
      chk("R7 irq_level_mode", int'(irq_level_mode), 1);
      rd_chk("R6 option readback", A_OPT, 8'h45, 1);

      // R8 R6: configuration/status
      wr(A_CS, 8'h40);
      @(negedge clk);
      chk("R8 stat_chg_en", int'(stat_chg_en), 1);
      rd_chk("R6 cfgsts readback", A_CS, 8'h40, 1);
      wr(A_CS, 8'hFF);
      rd_chk("R6 cfgsts mask", A_CS, 8'h7E, 1);
      wr(A_CS, 8'h40);
      wr(A_PR, 8'h00);
      rd_chk("R6 pinrep zero", A_PR, 8'h00, 1);
      wr(A_PR, 8'hFF);
      rd_chk("R6 pinrep mask", A_PR, 8'h0F, 1);

      // R1: unqualified writes and reads
      @(negedge clk);
      addr = ADDR_W'(A_OPT); wdata = 8'h00; reg_sel_n = 1'b1; ce1_n = 1'b0; we_n = 1'b0;
      @(negedge clk); idle();
      @(negedge clk);
      addr = ADDR_W'(A_OPT); wdata = 8'h00; reg_sel_n = 1'b0; ce1_n = 1'b1; we_n = 1'b0;
      @(negedge clk); idle();
      rd_chk("R1 option after unqualified writes", A_OPT, 8'h45, 1);
      @(negedge clk);
      addr = ADDR_W'(A_OPT); reg_sel_n = 1'b1; ce1_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      chk("R1 read without select oe", int'(rdata_oe), 0);
      chk("R1 read without select data", int'(rdata), 0);
      idle();

      // R12: writes to table, odd and unmapped addresses
      wr(0, 8'h55);
      wr(A_OPT + 1, 8'h00);
      wr(A_PR + 2, 8'h00);
      rd_chk("R12 table entry unchanged", 0, exp_cis(0), 1);
      rd_chk("R12 option unchanged", A_OPT, 8'h45, 1);
      rd_chk("R12 unmapped still zero", A_PR + 2, 0, 0);

      // R10: held write strobe writes once with first data
      @(negedge clk);
      addr = ADDR_W'(A_OPT); wdata = 8'h41; reg_sel_n = 1'b0; ce1_n = 1'b0; we_n = 1'b0;
      @(negedge clk); wdata = 8'h05;
      repeat (3) @(negedge clk);
      idle();
      rd_chk("R10 held write keeps first data", A_OPT, 8'h41, 1);
      wr(A_OPT, 8'h45);

      // R11: both strobes low is a read
      @(negedge clk);
      addr = ADDR_W'(A_OPT); wdata = 8'h00; reg_sel_n = 1'b0; ce1_n = 1'b0;
      oe_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      chk("R11 read data during both strobes", int'(rdata), 8'h45);
      idle();
      rd_chk("R11 no write happened", A_OPT, 8'h45, 1);

      // R9: soft reset
      wr(A_OPT, 8'hC5);
      @(negedge clk);
      chk("R9 io_func_en forced low", int'(io_func_en), 0);
      chk("R9 irq_route_en forced low", int'(irq_route_en), 0);
      chk("R9 stat_chg_en cleared", int'(stat_chg_en), 0);
      rd_chk("R9 cfgsts held", A_CS, 0, 1);
      rd_chk("R9 pinrep held", A_PR, 0, 1);
      wr(A_CS, 8'h40);
      rd_chk("R9 cfgsts write dropped", A_CS, 0, 1);
      rd_chk("R9 option keeps value", A_OPT, 8'hC5, 1);
      wr(A_OPT, 8'h00);
      rd_chk("R9 option cleared", A_OPT, 0, 1);
      wr(A_CS, 8'h40);
      @(negedge clk);
      chk("R9 cfgsts writable after clear", int'(stat_chg_en), 1);

      // R5: reset again restores zero
      wr(A_OPT, 8'h45);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_chk("R5 option after reset", A_OPT, 0, 1);
      rd_chk("R5 cfgsts after reset", A_CS, 0, 1);
      rd_chk("R5 pinrep after reset", A_PR, 0, 1);
      chk("R5 stat_chg_en after reset", int'(stat_chg_en), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule